// File: doc/BRIEF.md
# Transceiver Reset Sequencer

This block runs the reset sequence of a 10/100 Ethernet physical-layer transceiver. Three sources can start a reset. Power-on is an asynchronous active-low input, `por_n`, that also resets the sequencer itself. The hardware reset pin is active low and passes through a synchroniser before the sequencer sees it. The software reset is a one-cycle write strobe. The block does not drive the line driver, the PLLs or the MII datapath directly. It gives each of them an enable, a hold level or a pulse, and sets these signals in a fixed order as reset is entered and left.

Reset entry takes one step per clock. The MAC-side inputs are isolated first. Next the MAC-side outputs are forced low, then the transmit line is tri-stated, then the internal modules are held in reset. Finally the block parks in power-down, where the latching status bits are cleared. It stays in power-down while any request is present. Exit also takes one step per clock, in this order:

1. The block leaves power-down.
2. It captures the strapped management address into its register field.
3. It releases the modules, pulses register defaults and re-enables the transmitter.
4. It pulses PLL resynchronisation for a fixed number of cycles.
5. It releases the MAC-side pins last, and the software reset bit clears at the same moment.

A new request during exit aborts the exit and starts entry again. The release must come within 640 ns of the request being removed. With the default 20 ns clock that is 32 cycles. The default path takes 10 cycles.

States and transitions:
- `ST_RUN` goes to `ST_ISOLATE` on any request.
- `ST_ISOLATE`, `ST_DRIVE_LOW`, `ST_TX_OFF` and `ST_CORE_RST` each advance to the next state unconditionally. `ST_CORE_RST` advances to `ST_POWER_DOWN`.
- `ST_POWER_DOWN` stays put while a request is present and otherwise goes to `ST_WAKE`.
- `ST_WAKE`, `ST_ADDR_CAP`, `ST_ENABLE` and `ST_RESYNC` go to `ST_ISOLATE` on a request. Otherwise they advance in that order.
- `ST_RESYNC` goes to `ST_RUN` after `SYNC_CYC` cycles.

Top module: `phy_rst_ctrl`

## Requirements
- R1: While `por_n` is low, and directly after it returns high, the block is in power-down. In that state every hold output and `pwr_down` and `latch_clr` are 1, the pulse outputs are 0, `sw_rst_bit` is 0 and `phy_addr` is 0.
- R2: From normal operation, a software write raises `mac_in_iso` one clock later. A low level on `hw_rst_n` raises it three clocks later, through a two-stage synchroniser.
- R3: Entry raises `mac_in_iso`, `mac_out_low`, `tx_tristate` and `core_rst` in that order, one clock apart.
- R4: `pwr_down` and `latch_clr` rise one clock after `core_rst`. Both stay 1 while any request persists, and are 0 in every other step.
- R5: On exit, `pwr_down` falls first. `phy_addr` then takes the value `strap_addr` had in the clock after power-down was left.
- R6: Two clocks after power-down is left, `core_rst` and `tx_tristate` fall together, and `regs_dflt` is 1 for exactly one clock.
- R7: `pll_resync` is then 1 for `SYNC_CYC` (4) clocks. `mac_in_iso` and `mac_out_low` fall together at the clock after it ends, and no earlier.
- R8: The MAC pins are released no later than 32 clocks (640 ns) after `hw_rst_n` or `por_n` returns high. With the defaults this takes exactly 10 clocks.
- R9: A software write sets `sw_rst_bit`. The bit reads 1 until it clears on the clock at which the MAC pins are released.
- R10: A request in any exit step sends the block back to the isolate step on the next clock. In that step `mac_in_iso` is 1 and every later entry output is 0.
- R11: A request during the entry steps does not restart or stall entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low, asynchronous to clk |
| sw_rst_wr | input | 1 | Software reset write strobe, one cycle |
| strap_addr | input | 5 | Strapped management address |
| mac_in_iso | output | 1 | Isolate MAC-side inputs |
| mac_out_low | output | 1 | Force MAC-side outputs low |
| tx_tristate | output | 1 | Tri-state the twisted-pair transmitter |
| core_rst | output | 1 | Hold internal modules in reset |
| pwr_down | output | 1 | Power-down flag |
| latch_clr | output | 1 | Clear latching status bits |
| regs_dflt | output | 1 | One-cycle pulse that restores management register defaults |
| pll_resync | output | 1 | Transmit and receive PLL resynchronisation |
| sw_rst_bit | output | 1 | Software reset bit, clears itself |
| phy_addr | output | 5 | Captured management address field |

## Verification
A wrong state in this sequencer shows on the ports as a broken cumulative pattern of the hold outputs within one clock. Examples are a `mac_out_low` without `mac_in_iso`, a skipped `regs_dflt` pulse, or a `pll_resync` count other than four. A wrong capture step shows as a stale `phy_addr` from the release onward. A lost abort shows as `regs_dflt` or `pll_resync` continuing when `mac_out_low` should have fallen back to 0. The bench runs a step-by-step reference model beside the design and compares every output at each clock. A divergence is therefore reported at the clock it appears.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_ISOLATE,
        ST_DRIVE_LOW,
        ST_TX_OFF,
        ST_CORE_RST,
        ST_POWER_DOWN,
        ST_WAKE,
        ST_ADDR_CAP,
        ST_ENABLE,
        ST_RESYNC
    } seq_state_t;

    typedef struct packed {
        logic mac_in_iso;
        logic mac_out_low;
        logic tx_tristate;
        logic core_rst;
        logic pwr_down;
        logic latch_clr;
        logic regs_dflt;
        logic pll_resync;
        logic addr_cap;
    } seq_out_t;

endpackage

// File: rtl/phy_rst_req.sv
module phy_rst_req #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic hw_rst_n,
    input  logic sw_rst_wr,
    input  logic seq_done,
    output logic req,
    output logic sw_rst_bit
);
    logic [SYNC_STAGES-1:0] pin_sync;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) pin_sync <= '0;
                else        pin_sync <= hw_rst_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) pin_sync <= '0;
                else        pin_sync <= {pin_sync[SYNC_STAGES-2:0], hw_rst_n};
            end
        end
    endgenerate

    assign req = ~pin_sync[SYNC_STAGES-1] | sw_rst_wr;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)         sw_rst_bit <= 1'b0;
        else if (sw_rst_wr) sw_rst_bit <= 1'b1;
        else if (seq_done)  sw_rst_bit <= 1'b0;
    end
endmodule

// File: rtl/phy_rst_fsm.sv
module phy_rst_fsm
    import phy_rst_pkg::*;
#(
    parameter int SYNC_CYC       = 4,
    parameter int SYNC_STAGES    = 2,
    parameter int REL_BUDGET_CYC = 32
) (
    input  logic     clk,
    input  logic     por_n,
    input  logic     req,
    output seq_out_t outs,
    output logic     seq_done
);
    localparam int CW = (SYNC_CYC > 1) ? $clog2(SYNC_CYC) : 1;
    localparam int BW = $clog2(REL_BUDGET_CYC + 2);
    localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_CYC - 1);

    seq_state_t state, state_nx;
    logic [CW-1:0] sync_cnt;
    logic [BW-1:0] exit_cnt;
    logic          in_exit;

    assign in_exit  = (state == ST_WAKE) || (state == ST_ADDR_CAP) ||
                      (state == ST_ENABLE) || (state == ST_RESYNC);
    assign seq_done = (state == ST_RESYNC) && (sync_cnt == SYNC_LAST) && !req;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:        if (req) state_nx = ST_ISOLATE;
            ST_ISOLATE:    state_nx = ST_DRIVE_LOW;
            ST_DRIVE_LOW:  state_nx = ST_TX_OFF;
            ST_TX_OFF:     state_nx = ST_CORE_RST;
            ST_CORE_RST:   state_nx = ST_POWER_DOWN;
            ST_POWER_DOWN: if (!req) state_nx = ST_WAKE;
            ST_WAKE:       state_nx = req ? ST_ISOLATE : ST_ADDR_CAP;
            ST_ADDR_CAP:   state_nx = req ? ST_ISOLATE : ST_ENABLE;
            ST_ENABLE:     state_nx = req ? ST_ISOLATE : ST_RESYNC;
            ST_RESYNC:     if (req) state_nx = ST_ISOLATE;
                           else if (sync_cnt == SYNC_LAST) state_nx = ST_RUN;
            default:       state_nx = ST_POWER_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state    <= ST_POWER_DOWN;
            sync_cnt <= '0;
            exit_cnt <= '0;
        end else begin
            state    <= state_nx;
            sync_cnt <= (state == ST_RESYNC && state_nx == ST_RESYNC) ? sync_cnt + 1'b1 : '0;
            if (state_nx inside {ST_WAKE, ST_ADDR_CAP, ST_ENABLE, ST_RESYNC}) begin
                if (exit_cnt != '1) exit_cnt <= exit_cnt + 1'b1;
            end else begin
                exit_cnt <= '0;
            end
        end
    end

    always_comb begin
        outs = '0;
        unique case (state)
            ST_RUN:        outs = '0;
            ST_ISOLATE:    outs.mac_in_iso = 1'b1;
            ST_DRIVE_LOW:  begin
                outs.mac_in_iso  = 1'b1;
                outs.mac_out_low = 1'b1;
            end
            ST_TX_OFF:     begin
                outs.mac_in_iso  = 1'b1;
                outs.mac_out_low = 1'b1;
                outs.tx_tristate = 1'b1;
            end
            ST_CORE_RST, ST_WAKE: begin
                outs.mac_in_iso  = 1'b1;
                outs.mac_out_low = 1'b1;
                outs.tx_tristate = 1'b1;
                outs.core_rst    = 1'b1;
            end
            ST_POWER_DOWN: begin
                outs.mac_in_iso  = 1'b1;
                outs.mac_out_low = 1'b1;
                outs.tx_tristate = 1'b1;
                outs.core_rst    = 1'b1;
                outs.pwr_down    = 1'b1;
                outs.latch_clr   = 1'b1;
            end
            ST_ADDR_CAP:   begin
                outs.mac_in_iso  = 1'b1;
                outs.mac_out_low = 1'b1;
                outs.tx_tristate = 1'b1;
                outs.core_rst    = 1'b1;
                outs.addr_cap    = 1'b1;
            end
            ST_ENABLE:     begin
                outs.mac_in_iso  = 1'b1;
                outs.mac_out_low = 1'b1;
                outs.regs_dflt   = 1'b1;
            end
            ST_RESYNC:     begin
                outs.mac_in_iso  = 1'b1;
                outs.mac_out_low = 1'b1;
                outs.pll_resync  = 1'b1;
            end
            default:       outs = '0;
        endcase
    end

    // R8: exit time plus synchroniser delay stays inside the release budget
    p_release_budget_r8: assert property (@(posedge clk) disable iff (!por_n)
        in_exit |-> (int'(exit_cnt) + SYNC_STAGES + 1 <= REL_BUDGET_CYC));

    // R10: a request in any exit step returns to the isolate step
    p_exit_abort_r10: assert property (@(posedge clk) disable iff (!por_n)
        (in_exit && req) |=> (outs.mac_in_iso && !outs.mac_out_low));

    // R4: power-down is held while a request persists
    p_pd_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
        (outs.pwr_down && req) |=> outs.pwr_down);
endmodule

// File: rtl/phy_rst_addr.sv
module phy_rst_addr #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              cap,
    input  logic [ADDR_W-1:0] strap,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)   addr <= '0;
        else if (cap) addr <= strap;
    end

    // R5: the field only changes at a capture step
    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!por_n)
        !$past(cap) |-> $stable(addr));
endmodule

// File: rtl/phy_rst_ctrl.sv
module phy_rst_ctrl #(
    parameter int CLK_NS       = 20,
    parameter int REL_LIMIT_NS = 640,
    parameter int SYNC_STAGES  = 2,
    parameter int SYNC_CYC     = 4,
    parameter int ADDR_W       = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hw_rst_n,
    input  logic              sw_rst_wr,
    input  logic [ADDR_W-1:0] strap_addr,
    output logic              mac_in_iso,
    output logic              mac_out_low,
    output logic              tx_tristate,
    output logic              core_rst,
    output logic              pwr_down,
    output logic              latch_clr,
    output logic              regs_dflt,
    output logic              pll_resync,
    output logic              sw_rst_bit,
    output logic [ADDR_W-1:0] phy_addr
);
    import phy_rst_pkg::*;

    localparam int REL_BUDGET_CYC = REL_LIMIT_NS / CLK_NS;

    logic     req, seq_done;
    seq_out_t outs;

    phy_rst_req #(.SYNC_STAGES(SYNC_STAGES)) u_req (
        .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .sw_rst_wr(sw_rst_wr),
        .seq_done(seq_done), .req(req), .sw_rst_bit(sw_rst_bit)
    );

    phy_rst_fsm #(
        .SYNC_CYC(SYNC_CYC), .SYNC_STAGES(SYNC_STAGES), .REL_BUDGET_CYC(REL_BUDGET_CYC)
    ) u_fsm (
        .clk(clk), .por_n(por_n), .req(req), .outs(outs), .seq_done(seq_done)
    );

    phy_rst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .por_n(por_n), .cap(outs.addr_cap), .strap(strap_addr), .addr(phy_addr)
    );

    assign mac_in_iso  = outs.mac_in_iso;
    assign mac_out_low = outs.mac_out_low;
    assign tx_tristate = outs.tx_tristate;
    assign core_rst    = outs.core_rst;
    assign pwr_down    = outs.pwr_down;
    assign latch_clr   = outs.latch_clr;
    assign regs_dflt   = outs.regs_dflt;
    assign pll_resync  = outs.pll_resync;

    // R3: outputs are not forced low before the inputs are isolated
    p_iso_before_low_r3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(mac_out_low) |-> $past(mac_in_iso));

    // R7: the MAC pins are released last, right after resync
    p_release_last_r7: assert property (@(posedge clk) disable iff (!por_n)
        $fell(mac_in_iso) |-> (!core_rst && !tx_tristate && !pwr_down && $past(pll_resync)));

    // R9: the software bit clears only together with the release
    p_swbit_clear_r9: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sw_rst_bit) |-> !mac_in_iso);
endmodule

// File: tb/phy_rst_ctrl_test.sv
`timescale 1ns/1ps
module phy_rst_ctrl_test;
    localparam int SYNC_CYC = 4;

    logic       clk = 1'b0;
    logic       por_n, hw_rst_n, sw_rst_wr;
    logic [4:0] strap_addr;
    logic       mac_in_iso, mac_out_low, tx_tristate, core_rst, pwr_down;
    logic       latch_clr, regs_dflt, pll_resync, sw_rst_bit;
    logic [4:0] phy_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    phy_rst_ctrl uut (
        .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .sw_rst_wr(sw_rst_wr),
        .strap_addr(strap_addr), .mac_in_iso(mac_in_iso), .mac_out_low(mac_out_low),
        .tx_tristate(tx_tristate), .core_rst(core_rst), .pwr_down(pwr_down),
        .latch_clr(latch_clr), .regs_dflt(regs_dflt), .pll_resync(pll_resync),
        .sw_rst_bit(sw_rst_bit), .phy_addr(phy_addr)
    );

    // Reference model: phase 0 run, 1..4 entry steps, 5 power-down,
    // 6 wake, 7 address capture, 8 enable, 9 resync
    int       m_ph  = 5;
    int       m_cnt = 0;
    bit       m_pin[$] = '{1'b0, 1'b0};
    bit       m_sw  = 1'b0;
    bit [4:0] m_addr = '0;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_ph = 5; m_cnt = 0; m_pin = '{1'b0, 1'b0}; m_sw = 1'b0; m_addr = '0;
        end else begin
            bit rq;
            int nxt;
            rq  = (m_pin[$] == 1'b0) || sw_rst_wr;
            nxt = m_ph;
            if (m_ph == 0)                      nxt = rq ? 1 : 0;
            else if (m_ph >= 1 && m_ph <= 4)    nxt = m_ph + 1;
            else if (m_ph == 5)                 nxt = rq ? 5 : 6;
            else if (rq)                        nxt = 1;
            else if (m_ph < 9)                  nxt = m_ph + 1;
            else if (m_cnt == SYNC_CYC - 1)     nxt = 0;
            if (sw_rst_wr)                      m_sw = 1'b1;
            else if (m_ph == 9 && nxt == 0)     m_sw = 1'b0;
            if (m_ph == 7)                      m_addr = strap_addr;
            m_cnt = (m_ph == 9 && nxt == 9) ? m_cnt + 1 : 0;
            m_ph  = nxt;
            m_pin.push_front(hw_rst_n);
            void'(m_pin.pop_back());
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            string t1, t4;
            t1 = por_n ? "R3" : "R1";
            t4 = por_n ? "R4" : "R1";
            chk(t1, "mac_in_iso",  mac_in_iso,  (m_ph >= 1));
            chk(t1, "mac_out_low", mac_out_low, (m_ph >= 2));
            chk(t1, "tx_tristate", tx_tristate, (m_ph >= 3 && m_ph <= 7));
            chk(t1, "core_rst",    core_rst,    (m_ph >= 4 && m_ph <= 7));
            chk(t4, "pwr_down",    pwr_down,    (m_ph == 5));
            chk(t4, "latch_clr",   latch_clr,   (m_ph == 5));
            chk("R6", "regs_dflt", regs_dflt,   (m_ph == 8));
            chk("R7", "pll_resync", pll_resync, (m_ph == 9));
            chk("R9", "sw_rst_bit", sw_rst_bit, m_sw);
            chk("R5", "phy_addr",  phy_addr,    m_addr);
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic wait_release(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (mac_in_iso && n < 60);
    endtask

    int n;

    initial begin
        por_n = 1'b0; hw_rst_n = 1'b1; sw_rst_wr = 1'b0; strap_addr = 5'h0A;
        repeat (3) tick();
        // R1: power-on holds the power-down pattern
        chk("R1", "por pwr_down", pwr_down, 1);
        chk("R1", "por phy_addr", phy_addr, 0);
        chk("R1", "por sw_rst_bit", sw_rst_bit, 0);
        por_n = 1'b1;
        wait_release(n);
        chk("R8", "release cycles after por", n, 10);
        chk("R5", "captured strap", phy_addr, 5'h0A);

        // hardware pin reset
        strap_addr = 5'h15;
        hw_rst_n = 1'b0;
        n = 0;
        do begin tick(); n++; end while (!mac_in_iso && n < 20);
        chk("R2", "pin to isolate cycles", n, 3);
        repeat (6) tick();
        hw_rst_n = 1'b1;
        wait_release(n);
        chk("R8", "release cycles after pin", n, 10);
        chk("R8", "within 640 ns budget", (n <= 32), 1);
        chk("R5", "captured strap", phy_addr, 5'h15);

        // software reset
        sw_rst_wr = 1'b1;
        tick();
        sw_rst_wr = 1'b0;
        chk("R2", "sw write isolates in one cycle", mac_in_iso, 1);
        chk("R9", "sw bit set", sw_rst_bit, 1);
        // R11: a write during entry does not restart it
        tick();
        sw_rst_wr = 1'b1;
        tick();
        sw_rst_wr = 1'b0;
        chk("R11", "entry continues to tx off", tx_tristate, 1);
        wait_release(n);
        chk("R9", "sw bit cleared at release", sw_rst_bit, 0);

        // R10: abort during the enable step
        hw_rst_n = 1'b0;
        repeat (8) tick();
        hw_rst_n = 1'b1;
        n = 0;
        while (!regs_dflt && n < 20) begin tick(); n++; end
        sw_rst_wr = 1'b1;
        tick();
        sw_rst_wr = 1'b0;
        chk("R10", "abort back to isolate", {mac_in_iso, mac_out_low, regs_dflt, pll_resync}, 4'b1000);
        wait_release(n);
        chk("R10", "released after restart", mac_in_iso, 0);

        // power-on in the middle of an exit
        hw_rst_n = 1'b0;
        repeat (8) tick();
        hw_rst_n = 1'b1;
        repeat (5) tick();
        por_n = 1'b0;
        tick();
        chk("R1", "por during exit", {pwr_down, pll_resync, sw_rst_bit}, 3'b100);
        por_n = 1'b1;
        wait_release(n);
        chk("R8", "release after mid-exit por", n, 10);

        repeat (3) tick();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1'b1;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule